// File: doc/BRIEF.md
# Cascaded 32-bit Quadrature Timer with Cross-Channel Capture

The block pairs two 16-bit counting channels into one 32-bit count. The low channel counts either a prescaled tick of the system clock or, in phase mode, the steps of a quadrature encoder on two inputs. The high channel can take the low channel's wrap events as its source. A wrap from all-ones to zero adds one to the high half. In phase mode, a wrap from zero to all-ones takes one from the high half. Either way, the joined 32-bit value stays coherent in every cycle. If the high channel is placed in phase mode itself, it ignores its source field and counts its own encoder inputs.

Each channel has two capture registers, A and B, each fed by its own pin with its own edge choice. A four-bit routing register lets a capture register also take the matching pin of the other channel. One pin edge can then snapshot both 16-bit halves together. Software reaches all state through a write port and a combinational read port.

Each quadrature decoder is a four-state machine whose state is the last synchronized `{A,B}` level: `PH00`, `PH10`, `PH11` and `PH01`. The forward ring is `PH00→PH10→PH11→PH01→PH00` and it yields an up step. The reverse ring yields a down step. Staying in place, or a jump across the ring (both inputs changed), leaves the state machine in the new state and gives no step.

Top module: `casc_timer32`

Register map (write address `wr_addr`, read address `rd_addr`):
- 0 low control and 1 high control, each 8 bits:
  - [2:0] source: 0 stopped, 1 every cycle, 2 one cycle in 4, 3 one cycle in 16, 7 cascade (high only), other codes stopped.
  - [3] phase mode.
  - [5:4] edge for capture A and [7:6] edge for capture B: 00 rising, 01 falling, 1x both.
- 2 low counter and 3 high counter: read/write.
- 4 low capture A, 5 low capture B, 6 high capture A and 7 high capture B: read only.
- 8 routing enables:
  - bit0: high A also takes the low A pin.
  - bit1: high B also takes the low B pin.
  - bit2: low A also takes the high A pin.
  - bit3: low B also takes the high B pin.

## Requirements
- R1: After reset, both counters, all four capture registers, both control registers and the routing register read 0, and `count32` is 0.
- R2: `count32` equals the high counter in bits 31:16 and the low counter in bits 15:0.
- R3: When the high source field is 7 and the high channel is not in phase mode, a low counter wrap from 0xFFFF to 0x0000 adds one to the high counter in the same clock edge.
- R4: Under the same setting, with the low channel in phase mode, a low wrap from 0x0000 to 0xFFFF subtracts one from the high counter in the same edge.
- R5: Outside phase mode the low counter never counts down. A low wrap leaves the high counter unchanged unless the high source field is 7.
- R6: With the high phase bit set, the high counter ignores its source field and low wraps, and steps only on its own quadrature inputs.
- R7: In phase mode a counter moves +1 on each step of the forward ring and −1 on each step of the reverse ring, on all four edges of an input cycle. A jump where both inputs change gives no count. The count lands on the third rising clock edge after the input change.
- R8: A capture register loads its own channel's counter on the selected edge of its pin (00 rising, 01 falling, 1x both). An edge of the other polarity has no effect. The load lands on the third clock edge after the pin change.
- R9: With a routing bit at 0, a capture register responds only to its own pin. With it at 1, it loads on the selected edge of either its own pin or the sibling pin, following the bit map above.
- R10: A write to a counter in the same cycle as a count or carry for that counter wins. The following cycle, it holds the written value.
- R11: Low source codes 1, 2 and 3 give exactly 1, 1/4 and 1/16 counts per cycle over any 64-cycle window. Codes 0 and 4–6 stop the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| lo_qa | input | 1 | Low channel encoder input A |
| lo_qb | input | 1 | Low channel encoder input B |
| hi_qa | input | 1 | High channel encoder input A |
| hi_qb | input | 1 | High channel encoder input B |
| lo_cap_a | input | 1 | Low channel capture pin A |
| lo_cap_b | input | 1 | Low channel capture pin B |
| hi_cap_a | input | 1 | High channel capture pin A |
| hi_cap_b | input | 1 | High channel capture pin B |
| count32 | output | 32 | Joined 32-bit count |

## Verification
A register write takes effect at the edge that samples it, so counter and control values are read back one cycle later. Encoder steps and capture pin edges pass two synchronizer flops and one registered update, so they land three edges after the pin change. Every check waits at least four or five cycles after such a stimulus, and at least one full cycle after a write. Each check is queued as an expected item only once the design is quiet. A monitor then compares it half a cycle away from the clock edge.

// File: rtl/casc_pkg.sv
package casc_pkg;

    typedef enum logic [1:0] {
        PH00 = 2'b00,
        PH10 = 2'b10,
        PH11 = 2'b11,
        PH01 = 2'b01
    } qphase_t;

    typedef struct packed {
        logic [1:0] edge_b;
        logic [1:0] edge_a;
        logic       phase;
        logic [2:0] src;
    } chan_ctl_t;

    localparam int CTL_W = $bits(chan_ctl_t);
    localparam int XR_W  = 4;

    localparam logic [2:0] SRC_STOP  = 3'd0;
    localparam logic [2:0] SRC_ALL   = 3'd1;
    localparam logic [2:0] SRC_DIV4  = 3'd2;
    localparam logic [2:0] SRC_DIV16 = 3'd3;
    localparam logic [2:0] SRC_CASC  = 3'd7;

    localparam logic [3:0] A_LO_CTL  = 4'd0;
    localparam logic [3:0] A_HI_CTL  = 4'd1;
    localparam logic [3:0] A_LO_CNT  = 4'd2;
    localparam logic [3:0] A_HI_CNT  = 4'd3;
    localparam logic [3:0] A_LO_CPA  = 4'd4;
    localparam logic [3:0] A_LO_CPB  = 4'd5;
    localparam logic [3:0] A_HI_CPA  = 4'd6;
    localparam logic [3:0] A_HI_CPB  = 4'd7;
    localparam logic [3:0] A_XROUTE  = 4'd8;

    function automatic logic edge_hit(input logic [1:0] mode,
                                      input logic cur, input logic prev);
        logic hit;
        case (mode)
            2'b00:   hit = cur & ~prev;
            2'b01:   hit = ~cur & prev;
            default: hit = cur ^ prev;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/casc_sync.sv
module casc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/casc_cap_in.sv
module casc_cap_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic cur,
    output logic prev
);
    logic s_out;

    casc_sync #(.W(1), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin),
        .dout (s_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= s_out;
    end

    assign cur = s_out;
endmodule

// File: rtl/casc_quad_dec.sv
module casc_quad_dec
    import casc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qa,
    input  logic qb,
    output logic step_up,
    output logic step_dn
);
    logic [1:0] ab_s;
    qphase_t    ph_q;
    qphase_t    ph_d;

    casc_sync #(.W(2), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({qa, qb}),
        .dout (ab_s)
    );

    assign ph_d = qphase_t'(ab_s);

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH00;
        else        ph_q <= ph_d;
    end

    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (ph_q)
            PH00: begin step_up = (ph_d == PH10); step_dn = (ph_d == PH01); end
            PH10: begin step_up = (ph_d == PH11); step_dn = (ph_d == PH00); end
            PH11: begin step_up = (ph_d == PH01); step_dn = (ph_d == PH10); end
            PH01: begin step_up = (ph_d == PH00); step_dn = (ph_d == PH11); end
        endcase
    end

    p_step_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

    p_jump_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_s == ~ph_q) |-> (!step_up && !step_dn));
endmodule

// File: rtl/casc_chan_cnt.sv
module casc_chan_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         wrap_up,
    output logic         wrap_dn
);
    localparam logic [W-1:0] MAXV = '1;

    assign wrap_up = inc & ~dec & ~wr & (cnt == MAXV);
    assign wrap_dn = dec & ~inc & ~wr & (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (wr)       cnt <= wdata;
        else if (inc & ~dec) cnt <= cnt + 1'b1;
        else if (dec & ~inc) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/casc_timer32.sv
module casc_timer32
    import casc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [3:0]         rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    input  logic               lo_qa,
    input  logic               lo_qb,
    input  logic               hi_qa,
    input  logic               hi_qb,
    input  logic               lo_cap_a,
    input  logic               lo_cap_b,
    input  logic               hi_cap_a,
    input  logic               hi_cap_b,
    output logic [2*CNT_W-1:0] count32
);
    localparam int NPIN = 4;
    localparam int P_LA = 0;
    localparam int P_LB = 1;
    localparam int P_HA = 2;
    localparam int P_HB = 3;

    chan_ctl_t          lo_ctl, hi_ctl;
    logic [XR_W-1:0]    xroute;
    logic [PRE_W-1:0]   pre;
    logic [CNT_W-1:0]   lo_cnt, hi_cnt;
    logic [CNT_W-1:0]   lo_cpa, lo_cpb, hi_cpa, hi_cpb;
    logic               lo_wr, hi_wr;
    logic               lo_qup, lo_qdn, hi_qup, hi_qdn;
    logic               lo_inc, lo_dec, hi_inc, hi_dec;
    logic               lo_wrap_up, lo_wrap_dn, hi_wrap_up, hi_wrap_dn;
    logic               hi_casc;
    logic [NPIN-1:0]    pins, pin_cur, pin_prev;
    logic               ev_lo_a, ev_lo_b, ev_hi_a, ev_hi_b;

    function automatic logic src_tick(input logic [2:0] s, input logic [PRE_W-1:0] p);
        logic t;
        case (s)
            SRC_ALL:   t = 1'b1;
            SRC_DIV4:  t = &p[1:0];
            SRC_DIV16: t = &p;
            default:   t = 1'b0;
        endcase
        return t;
    endfunction

    // register writes
    assign lo_wr = wr_en && (wr_addr == A_LO_CNT);
    assign hi_wr = wr_en && (wr_addr == A_HI_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_ctl <= '0;
            hi_ctl <= '0;
            xroute <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_LO_CTL: lo_ctl <= chan_ctl_t'(wr_data[CTL_W-1:0]);
                A_HI_CTL: hi_ctl <= chan_ctl_t'(wr_data[CTL_W-1:0]);
                A_XROUTE: xroute <= wr_data[XR_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre <= '0;
        else        pre <= pre + 1'b1;
    end

    // quadrature decoders
    casc_quad_dec #(.STAGES(SYNC_STAGES)) u_qlo (
        .clk(clk), .rst_n(rst_n), .qa(lo_qa), .qb(lo_qb),
        .step_up(lo_qup), .step_dn(lo_qdn)
    );
    casc_quad_dec #(.STAGES(SYNC_STAGES)) u_qhi (
        .clk(clk), .rst_n(rst_n), .qa(hi_qa), .qb(hi_qb),
        .step_up(hi_qup), .step_dn(hi_qdn)
    );

    // count sources
    assign hi_casc = !hi_ctl.phase && (hi_ctl.src == SRC_CASC);

    always_comb begin
        lo_inc = lo_ctl.phase ? lo_qup : src_tick(lo_ctl.src, pre);
        lo_dec = lo_ctl.phase & lo_qdn;
        if (hi_ctl.phase) begin
            hi_inc = hi_qup;
            hi_dec = hi_qdn;
        end else if (hi_casc) begin
            hi_inc = lo_wrap_up;
            hi_dec = lo_wrap_dn;
        end else begin
            hi_inc = src_tick(hi_ctl.src, pre);
            hi_dec = 1'b0;
        end
    end

    casc_chan_cnt #(.W(CNT_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .wr(lo_wr), .wdata(wr_data),
        .inc(lo_inc), .dec(lo_dec), .cnt(lo_cnt),
        .wrap_up(lo_wrap_up), .wrap_dn(lo_wrap_dn)
    );
    casc_chan_cnt #(.W(CNT_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .wr(hi_wr), .wdata(wr_data),
        .inc(hi_inc), .dec(hi_dec), .cnt(hi_cnt),
        .wrap_up(hi_wrap_up), .wrap_dn(hi_wrap_dn)
    );

    assign count32 = {hi_cnt, lo_cnt};

    // capture pins
    assign pins = {hi_cap_b, hi_cap_a, lo_cap_b, lo_cap_a};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        casc_cap_in #(.STAGES(SYNC_STAGES)) u_pin (
            .clk(clk), .rst_n(rst_n), .pin(pins[g]),
            .cur(pin_cur[g]), .prev(pin_prev[g])
        );
    end

    always_comb begin
        ev_lo_a = edge_hit(lo_ctl.edge_a, pin_cur[P_LA], pin_prev[P_LA])
                | (xroute[2] & edge_hit(lo_ctl.edge_a, pin_cur[P_HA], pin_prev[P_HA]));
        ev_lo_b = edge_hit(lo_ctl.edge_b, pin_cur[P_LB], pin_prev[P_LB])
                | (xroute[3] & edge_hit(lo_ctl.edge_b, pin_cur[P_HB], pin_prev[P_HB]));
        ev_hi_a = edge_hit(hi_ctl.edge_a, pin_cur[P_HA], pin_prev[P_HA])
                | (xroute[0] & edge_hit(hi_ctl.edge_a, pin_cur[P_LA], pin_prev[P_LA]));
        ev_hi_b = edge_hit(hi_ctl.edge_b, pin_cur[P_HB], pin_prev[P_HB])
                | (xroute[1] & edge_hit(hi_ctl.edge_b, pin_cur[P_LB], pin_prev[P_LB]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cpa <= '0;
            lo_cpb <= '0;
            hi_cpa <= '0;
            hi_cpb <= '0;
        end else begin
            if (ev_lo_a) lo_cpa <= lo_cnt;
            if (ev_lo_b) lo_cpb <= lo_cnt;
            if (ev_hi_a) hi_cpa <= hi_cnt;
            if (ev_hi_b) hi_cpb <= hi_cnt;
        end
    end

    // read port
    always_comb begin
        case (rd_addr)
            A_LO_CTL: rd_data = CNT_W'(lo_ctl);
            A_HI_CTL: rd_data = CNT_W'(hi_ctl);
            A_LO_CNT: rd_data = lo_cnt;
            A_HI_CNT: rd_data = hi_cnt;
            A_LO_CPA: rd_data = lo_cpa;
            A_LO_CPB: rd_data = lo_cpb;
            A_HI_CPA: rd_data = hi_cpa;
            A_HI_CPB: rd_data = hi_cpb;
            A_XROUTE: rd_data = CNT_W'(xroute);
            default:  rd_data = '0;
        endcase
    end

    // assertions
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (count32 == '0 && xroute == '0));

    p_carry_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wrap_up && hi_casc && !hi_wr) |=>
            (lo_cnt == '0 && hi_cnt == $past(hi_cnt) + 1'b1));

    p_carry_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wrap_dn && hi_casc && !hi_wr) |=>
            (lo_cnt == '1 && hi_cnt == $past(hi_cnt) - 1'b1));

    p_no_down_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_ctl.phase && !hi_ctl.phase && !hi_wr) |=>
            (hi_cnt == $past(hi_cnt) || hi_cnt == $past(hi_cnt) + 1'b1));

    p_hi_phase_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_ctl.phase && !hi_qup && !hi_qdn && !hi_wr) |=> $stable(hi_cnt));

    p_cap_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lo_a |=> (lo_cpa == $past(lo_cnt)));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (lo_cnt == $past(wr_data)));

    p_hi_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (hi_cnt == $past(wr_data)));
endmodule

// File: tb/test_casc_timer32.sv
module test_casc_timer32;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        lo_qa = 0, lo_qb = 0, hi_qa = 0, hi_qb = 0;
    logic        lo_cap_a = 0, lo_cap_b = 0, hi_cap_a = 0, hi_cap_b = 0;
    logic [31:0] count32;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mon_busy = 0;

    typedef struct {
        logic [3:0]  a;
        logic [31:0] exp;
        bit          w32;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    casc_timer32 i_casc_timer32 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .lo_qa(lo_qa), .lo_qb(lo_qb), .hi_qa(hi_qa), .hi_qb(hi_qb),
        .lo_cap_a(lo_cap_a), .lo_cap_b(lo_cap_b),
        .hi_cap_a(hi_cap_a), .hi_cap_b(hi_cap_b), .count32(count32)
    );

    localparam logic [3:0] LO_CTL = 0, HI_CTL = 1, LO_CNT = 2, HI_CNT = 3;
    localparam logic [3:0] LO_CPA = 4, LO_CPB = 5, HI_CPA = 6, HI_CPB = 7, XR = 8;

    // monitor: pops expected items and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                mon_busy = 1;
                it = sb.pop_front();
                rd_addr = it.a;
                #1;
                act = it.w32 ? count32 : {16'h0, rd_data};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
                mon_busy = 0;
            end
        end
    end

    task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.a = a; it.exp = e; it.w32 = 0; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0 && !mon_busy);
    endtask

    task automatic chk32(input logic [31:0] e, input string tag);
        item_t it;
        it.a = 0; it.exp = e; it.w32 = 1; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0 && !mon_busy);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic qlo(input logic [1:0] ab);
        @(negedge clk);
        {lo_qa, lo_qb} = ab;
        repeat (4) @(negedge clk);
    endtask

    task automatic qhi(input logic [1:0] ab);
        @(negedge clk);
        {hi_qa, hi_qb} = ab;
        repeat (4) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk(LO_CNT, 0, "R1 lo count");
        chk(HI_CNT, 0, "R1 hi count");
        chk(LO_CTL, 0, "R1 lo ctl");
        chk(XR, 0, "R1 route");
        chk(LO_CPA, 0, "R1 capture");
        chk32(0, "R1 count32");

        // R11 source codes
        wr(LO_CTL, 16'h0001); repeat (8) @(negedge clk); wr(LO_CTL, 16'h0000);
        chk(LO_CNT, 10, "R11 every cycle");
        wr(LO_CNT, 0); wr(LO_CTL, 16'h0002); repeat (62) @(negedge clk); wr(LO_CTL, 0);
        chk(LO_CNT, 16, "R11 div4");
        wr(LO_CNT, 0); wr(LO_CTL, 16'h0003); repeat (62) @(negedge clk); wr(LO_CTL, 0);
        chk(LO_CNT, 4, "R11 div16");
        wr(LO_CNT, 0); wr(LO_CTL, 16'h0005); repeat (8) @(negedge clk); wr(LO_CTL, 0);
        chk(LO_CNT, 0, "R11 code5 stopped");

        // R10 write beats count
        wr(LO_CTL, 16'h0001); wr(LO_CNT, 16'h5555); wr(LO_CTL, 0);
        chk(LO_CNT, 16'h5557, "R10 write priority");

        // R2 / R3 overflow carry
        wr(HI_CTL, 16'h0007); wr(HI_CNT, 16'h1234); wr(LO_CNT, 16'hFFFE);
        wr(LO_CTL, 16'h0001); wr(LO_CTL, 0);
        chk32(32'h1235_0000, "R3 R2 overflow carry");
        chk(HI_CNT, 16'h1235, "R3 hi count");

        // R5 no carry without cascade source
        wr(HI_CTL, 0); wr(LO_CNT, 16'hFFFF); wr(LO_CTL, 16'h0001); wr(LO_CTL, 0);
        chk32(32'h1235_0001, "R5 no cascade");

        // R7 / R4 phase mode in both directions
        wr(HI_CTL, 16'h0007); wr(HI_CNT, 16'h00A0); wr(LO_CNT, 16'hFFFE);
        wr(LO_CTL, 16'h0008);
        qlo(2'b10); qlo(2'b11); qlo(2'b01); qlo(2'b00);
        chk32(32'h00A1_0002, "R7 R3 forward across boundary");
        qlo(2'b01); qlo(2'b11); qlo(2'b10); qlo(2'b00);
        chk32(32'h00A0_FFFE, "R4 R7 reverse underflow borrow");
        qlo(2'b11);
        chk32(32'h00A0_FFFE, "R7 jump ignored");
        qlo(2'b00);
        chk32(32'h00A0_FFFE, "R7 jump back ignored");

        // R6 high in phase mode ignores cascade
        wr(HI_CTL, 16'h000F);
        qlo(2'b10); qlo(2'b11);
        chk32(32'h00A0_0000, "R6 no carry in hi phase");
        qhi(2'b10);
        chk32(32'h00A1_0000, "R6 own encoder step");
        qlo(2'b10); qlo(2'b00);
        wr(LO_CTL, 0); wr(HI_CTL, 0);

        // R8 edge selection
        wr(LO_CNT, 16'h1111); wr(HI_CNT, 16'h2222);
        @(negedge clk); lo_cap_a = 1; settle();
        chk(LO_CPA, 16'h1111, "R8 rising capture");
        chk(HI_CPA, 16'h0000, "R9 route off");
        wr(LO_CTL, 16'h0010); wr(LO_CNT, 16'h3333);
        @(negedge clk); lo_cap_a = 0; settle();
        chk(LO_CPA, 16'h3333, "R8 falling capture");
        wr(LO_CNT, 16'h4444);
        @(negedge clk); lo_cap_a = 1; settle();
        chk(LO_CPA, 16'h3333, "R8 rising ignored in falling mode");
        wr(LO_CTL, 16'h0020); wr(LO_CNT, 16'h5555);
        @(negedge clk); lo_cap_a = 0; settle();
        chk(LO_CPA, 16'h5555, "R8 both edges");

        // R9 cross routing
        wr(XR, 16'h0001);
        @(negedge clk); lo_cap_a = 1; settle();
        chk(LO_CPA, 16'h5555, "R9 own capture");
        chk(HI_CPA, 16'h2222, "R9 hiA from loA pin");
        wr(XR, 16'h0004); wr(LO_CNT, 16'h6666); wr(HI_CNT, 16'h7777);
        @(negedge clk); hi_cap_a = 1; settle();
        chk(HI_CPA, 16'h7777, "R9 hiA own pin");
        chk(LO_CPA, 16'h6666, "R9 loA from hiA pin");
        chk(LO_CPB, 16'h0000, "R9 loB untouched");
        wr(XR, 16'h0008); wr(LO_CNT, 16'h8888);
        @(negedge clk); hi_cap_b = 1; settle();
        chk(LO_CPB, 16'h8888, "R9 loB from hiB pin");
        chk(HI_CPB, 16'h7777, "R9 hiB own pin");
        chk(XR, 16'h0008, "R9 route readback");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule